// File: doc/BRIEF.md
# Packed Saturating Signed-to-Unsigned Left Shifter

This block is a SIMD datapath slice. It takes a 128-bit operand and reads every lane as a two's-complement integer. Each lane is shifted left by an immediate amount, and the shifted value is clamped into the unsigned range of that lane. The lane width and the shift distance both come from a single 7-bit immediate, which arrives as a 4-bit upper field and a 3-bit lower field. The width of the upper field's highest set bit picks the lane size. The shift is the whole immediate minus that lane size.

A mode input picks between two behaviours. In scalar mode the block works on one lane at the bottom of the operand. In vector mode it works on every lane of a 64-bit or a 128-bit window, and a width bit chooses which window. The result and the illegal-encoding flag are combinational. A registered sticky flag records that at least one lane was clamped. The flag holds until the clear input is asserted.

Top module: `sat_shl_u`

## Requirements
- R1: Lane width is 8, 16, 32 or 64 bits. The choice follows the highest set bit of `imm_hi`: bit 0 gives 8, bit 1 gives 16, bit 2 gives 32 and bit 3 gives 64. Lane k occupies bits [k*W+W-1 : k*W] of `operand` and of `result`.
- R2: The shift distance is the unsigned value {`imm_hi`,`imm_lo`} minus the lane width. This always falls in the range 0 to W-1.
- R3: When `imm_hi` is 0000, `illegal` is 1.
- R4: When `scalar_mode`=0, `wide_q`=0 and `imm_hi[3]`=1, `illegal` is 1. The same immediate with `scalar_mode`=1 is legal, whatever the value of `wide_q`.
- R5: In scalar mode only lane 0 is processed, and `result` bits at and above W are 0. `wide_q` has no effect in this mode.
- R6: In vector mode the window is 128 bits when `wide_q`=1 and 64 bits when `wide_q`=0. `result[127:64]` is 0 when `wide_q`=0.
- R7: A processed lane with a negative value yields 0 and counts as saturated.
- R8: A non-negative lane whose shifted value is 2^W or more yields all ones and counts as saturated.
- R9: In any other case the lane yields its value shifted left, exactly and without rounding, and does not saturate. A zero lane never saturates.
- R10: `sat_sticky` becomes 1 on the clock edge after a legal operation with any saturated lane. It then stays 1 until it is cleared.
- R11: `sat_clr` forces `sat_sticky` to 0 on the next edge. This takes priority over a saturation in the same cycle.
- R12: While `illegal` is 1, `result` is 0 and `sat_sticky` does not change, apart from a clear.
- R13: After reset, `sat_sticky` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the sticky flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| operand | input | 128 | Packed signed source lanes |
| imm_hi | input | 4 | Upper immediate field (selects lane width) |
| imm_lo | input | 3 | Lower immediate field |
| wide_q | input | 1 | Vector mode: 1 selects a 128-bit window, 0 a 64-bit window |
| scalar_mode | input | 1 | 1 processes a single lane |
| sat_clr | input | 1 | Clears the sticky saturation flag |
| result | output | 128 | Packed unsigned clamped lanes |
| illegal | output | 1 | Immediate/mode combination is not allowed |
| sat_sticky | output | 1 | Cumulative saturation flag |

## Verification
The hardest case to reach is a lane that sits exactly on the overflow boundary at the largest shift for its width. A slightly smaller value must pass through unchanged, while one more bit must clamp. Only a few operand values sit on that boundary for each lane size. The stimulus therefore sweeps every one of the 128 immediates in all three modes. For each immediate it applies fixed patterns (zero, all-ones, small positive, the largest positive value in every lane) alongside random operands. Before each legal or illegal vector the sticky flag is cleared, so the flag update is checked one vector at a time.

// File: rtl/sat_shl_u.sv
module sat_shl_u #(
  parameter int VW = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [VW-1:0] operand,
  input  logic [3:0]    imm_hi,
  input  logic [2:0]    imm_lo,
  input  logic          wide_q,
  input  logic          scalar_mode,
  input  logic          sat_clr,
  output logic [VW-1:0] result,
  output logic          illegal,
  output logic          sat_sticky
);
  localparam int NSZ = 4;
  localparam int MAXL = VW / 8;

  logic [1:0] szi;
  logic [6:0] shamt;
  logic [NSZ-1:0][VW-1:0] res_g;
  logic [NSZ-1:0][MAXL-1:0] sat_g;
  logic any_sat;

  assign szi = imm_hi[3] ? 2'd3 : imm_hi[2] ? 2'd2 : imm_hi[1] ? 2'd1 : 2'd0;
  assign shamt = {imm_hi, imm_lo} - (7'd8 << szi);
  assign illegal = (imm_hi == 4'd0) || (!scalar_mode && imm_hi[3] && !wide_q);

  for (genvar g = 0; g < NSZ; g++) begin : g_size
    localparam int E = 8 << g;
    localparam int N = VW / E;
    for (genvar i = 0; i < N; i++) begin : g_lane
      localparam bit FIRST = (i == 0);
      localparam bit LOW = ((i + 1) * E <= 64);
      logic [E-1:0] x;
      logic [2*E-1:0] shd;
      logic neg, ovf, act;
      assign x = operand[i*E +: E];
      assign shd = {{E{x[E-1]}}, x} << shamt;
      assign neg = x[E-1];
      assign ovf = !neg && (|shd[2*E-1:E]);
      assign act = scalar_mode ? FIRST : (wide_q || LOW);
      assign res_g[g][i*E +: E] = !act ? '0 : neg ? '0 : ovf ? '1 : shd[E-1:0];
      assign sat_g[g][i] = act && (neg || ovf);
    end
    if (N < MAXL) begin : g_pad
      assign sat_g[g][MAXL-1:N] = '0;
    end
  end

  assign result = illegal ? '0 : res_g[szi];
  assign any_sat = |sat_g[szi];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sat_sticky <= 1'b0;
    else if (sat_clr) sat_sticky <= 1'b0;
    else if (!illegal && any_sat) sat_sticky <= 1'b1;
  end

  a_r3_hi_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (imm_hi == 4'd0) |-> illegal);
  a_r12_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (result == '0));
  a_r5_scalar_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (scalar_mode && imm_hi == 4'b0001) |-> (result[VW-1:8] == '0));
  a_r10_sticky_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_sticky && !sat_clr) |=> sat_sticky);
  a_r10_sticky_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_clr && !illegal && any_sat) |=> sat_sticky);
  a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clr |=> !sat_sticky);
  a_r12_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_sticky && illegal && !sat_clr) |=> !sat_sticky);
endmodule

// File: tb/sat_shl_u_tb_top.sv
module sat_shl_u_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [127:0] operand = '0;
  logic [3:0] imm_hi = 4'd1;
  logic [2:0] imm_lo = 3'd0;
  logic wide_q = 1'b0, scalar_mode = 1'b0, sat_clr = 1'b0;
  logic [127:0] result;
  logic illegal, sat_sticky;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sat_shl_u dut_i (.clk(clk), .rst_n(rst_n), .operand(operand), .imm_hi(imm_hi),
    .imm_lo(imm_lo), .wide_q(wide_q), .scalar_mode(scalar_mode), .sat_clr(sat_clr),
    .result(result), .illegal(illegal), .sat_sticky(sat_sticky));

  logic [127:0] e_res;
  logic e_ill, e_sat;

  task automatic model();
    int w, sh, lanes;
    logic [127:0] msk, raw, v;
    w = imm_hi[3] ? 64 : imm_hi[2] ? 32 : imm_hi[1] ? 16 : 8;
    sh = int'({imm_hi, imm_lo}) - w;
    e_ill = (imm_hi == 0) || (!scalar_mode && imm_hi[3] && !wide_q);
    lanes = scalar_mode ? 1 : (wide_q ? 128 : 64) / w;
    msk = (128'd1 << w) - 128'd1;
    e_res = '0;
    e_sat = 1'b0;
    if (!e_ill) begin
      for (int k = 0; k < lanes; k++) begin
        raw = (operand >> (k * w)) & msk;
        if (raw[w-1]) begin
          v = '0; e_sat = 1'b1;            // R7
        end else begin
          v = raw << sh;
          if ((v >> w) != 0) begin v = msk; e_sat = 1'b1; end  // R8
        end
        e_res = e_res | (v << (k * w));    // R1 R2 R9
      end
    end
  endtask

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (hi=%b lo=%b sc=%b q=%b)", tag, act, exp,
               imm_hi, imm_lo, scalar_mode, wide_q);
    end
  endtask

  function automatic logic [127:0] pat(input int p);
    case (p)
      0: return '0;
      1: return '1;
      2: return {16{8'h01}};
      3: return {16{8'h7F}};
      4: return {8{16'h7FFF}};
      5: return {4{32'h7FFF_FFFF}};
      6: return {2{64'h7FFF_FFFF_FFFF_FFFF}};
      7: return {8{16'h0080}};
      default: return {$urandom, $urandom, $urandom, $urandom};
    endcase
  endfunction

  initial begin
    repeat (2) @(negedge clk);
    check(sat_sticky == 1'b0, "R13 reset", {127'd0, sat_sticky}, '0);
    rst_n = 1'b1;
    for (int h = 0; h < 16; h++)
      for (int l = 0; l < 8; l++)
        for (int m = 0; m < 3; m++)
          for (int p = 0; p < 11; p++) begin
            @(negedge clk);
            imm_hi = 4'(h); imm_lo = 3'(l);
            scalar_mode = (m == 0); wide_q = (m == 2);
            if (m == 0 && p[0]) wide_q = 1'b1;   // R5: Q ignored in scalar
            operand = pat(p);
            sat_clr = 1'b1;
            #1 model();
            check(result == e_res, "R1 R2 R5 R6 R7 R8 R9 R12 result", result, e_res);
            check(illegal == e_ill, "R3 R4 illegal", {127'd0, illegal}, {127'd0, e_ill});
            @(negedge clk);
            sat_clr = 1'b0;
            @(negedge clk);
            check(sat_sticky == e_sat, "R10 R12 sticky", {127'd0, sat_sticky}, {127'd0, e_sat});
          end
    // R10 hold across a non-saturating op
    @(negedge clk);
    imm_hi = 4'b0001; imm_lo = 3'd0; scalar_mode = 1'b0; wide_q = 1'b1; operand = '1;
    @(negedge clk);
    operand = '0;
    @(negedge clk); @(negedge clk);
    check(sat_sticky == 1'b1, "R10 hold", {127'd0, sat_sticky}, 128'd1);
    // R11 clear wins over same-cycle saturation
    operand = '1; sat_clr = 1'b1;
    @(negedge clk);
    check(sat_sticky == 1'b0, "R11 clear priority", {127'd0, sat_sticky}, '0);
    // R12 illegal saturating operand leaves flag clear
    sat_clr = 1'b0; imm_hi = 4'b1000; wide_q = 1'b0; operand = '1;
    @(negedge clk); @(negedge clk);
    check(sat_sticky == 1'b0, "R12 illegal no set", {127'd0, sat_sticky}, '0);
    check(result == '0, "R12 illegal zero", result, '0);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule